// File: doc/BRIEF.md
# Dual-Tone Digital Frequency Synthesizer

This block turns a decoded keypad selection into a stream of signed digital samples holding one low-group (row) tone, one high-group (column) tone, or their sum. It runs from a 3.579545 MHz reference clock. Every frequency comes from a fixed integer divider on that clock: each group counts the reference down by its divisor and steps through a 32-point sine table. Each group therefore lands on a slightly non-ideal frequency that stays within 0.75 % of its nominal value.

The column group is pre-emphasised by a factor of 1.25, which is about 1.94 dB above the row group. The two contributions are added and clipped to the output width, and then registered. A decoder upstream supplies a 2-bit row select, a 2-bit column select and one enable for each group. Sixteen row/column pairs give the dual tones. Enabling a single group gives one of the eight single tones. A global off flag mutes everything.

Top module: `dtmf_synth`

## Requirements
- R1: While rst_ni is low, sample_o is 0 and valid_o is 0.
- R2: With only the row group active, the period of sample_o is 32·N clock cycles, where N is 160, 146, 132 or 118 for row_sel_i = 0, 1, 2 or 3. These give about 699, 766, 847 and 948 Hz for nominal 697, 770, 852 and 941 Hz, each within 0.75 %.
- R3: With only the column group active, the period is 32·N cycles, where N is 92, 84, 76 or 68 for col_sel_i = 0, 1, 2 or 3. These give about 1216, 1332, 1472 and 1645 Hz for nominal 1209, 1336, 1477 and 1633 Hz, each within 0.75 %.
- R4: An active group advances its table index k (0..31, wrapping) by one each time its cycle counter reaches N-1. The counter is compared with the divisor currently selected, so a select change takes effect at once. The table value is round(32767·sin(2πk/32)).
- R5: The row contribution is r = table >>> AMP_SHIFT, with an arithmetic shift. The column contribution is c + (c >>> 2), where c = table >>> AMP_SHIFT. With the default shift of 2 this gives a row peak of 8191 and a column range of -10240..10238.
- R6: On each clock, sample_o takes the clipped sum of the active contributions, computed from the current indices and enables. valid_o takes the value of "any group active" on the same edge.
- R7: The sum is clipped to the signed OUT_W range: 32767 and -32768 at OUT_W = 16.
- R8: An inactive group contributes 0. With neither group active, sample_o is 0 and valid_o is 0 from the next cycle on.
- R9: off_i = 1 deactivates both groups whatever their enables are.
- R10: An inactive group holds its counter and index at 0. When it is re-enabled, sample_o first turns positive N+1 cycles after the first active edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 3.579545 MHz reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| row_sel_i | input | 2 | Row tone select |
| col_sel_i | input | 2 | Column tone select |
| row_en_i | input | 1 | Row group enable |
| col_en_i | input | 1 | Column group enable |
| off_i | input | 1 | Mute both groups |
| sample_o | output | OUT_W | Signed summed sample |
| valid_o | output | 1 | At least one group active in this sample |

## Verification
The bench builds two instances on shared inputs. One uses the default AMP_SHIFT of 2, which gives headroom, so every selected frequency and both peak amplitudes can be checked exactly against a behavioural model. The other uses AMP_SHIFT = 0, where the pre-emphasised column alone exceeds full scale, so both clipping rails are reached within one row period. With OUT_W = 16 the rails are ±32767/-32768, and the measured tone periods are converted to hertz against the 3.579545 MHz reference.

// File: rtl/dtmf_pkg.sv
package dtmf_pkg;
  localparam int IDX_W = 5;
  localparam int TBL_W = 17;
  localparam int DIV_W = 8;
  localparam int NGRP  = 2;
  localparam int SEL_W = 2;

  typedef logic [DIV_W-1:0] div_t;
  typedef logic [IDX_W-1:0] idx_t;
  typedef logic signed [TBL_W-1:0] tbl_t;

  // low group divisors of the 3.579545 MHz reference (32 steps per period)
  function automatic div_t row_div(logic [SEL_W-1:0] sel);
    case (sel)
      2'd0:    return div_t'(160);
      2'd1:    return div_t'(146);
      2'd2:    return div_t'(132);
      default: return div_t'(118);
    endcase
  endfunction

  function automatic div_t col_div(logic [SEL_W-1:0] sel);
    case (sel)
      2'd0:    return div_t'(92);
      2'd1:    return div_t'(84);
      2'd2:    return div_t'(76);
      default: return div_t'(68);
    endcase
  endfunction

  // quarter-wave table, mirrored and negated for the full period
  function automatic tbl_t sine_at(idx_t idx);
    logic [3:0] j;
    logic [3:0] k;
    tbl_t mag;
    j = idx[3:0];
    k = (j > 4'd8) ? 4'(5'd16 - {1'b0, j}) : j;
    case (k)
      4'd0:    mag = tbl_t'(0);
      4'd1:    mag = tbl_t'(6393);
      4'd2:    mag = tbl_t'(12539);
      4'd3:    mag = tbl_t'(18204);
      4'd4:    mag = tbl_t'(23170);
      4'd5:    mag = tbl_t'(27245);
      4'd6:    mag = tbl_t'(30273);
      4'd7:    mag = tbl_t'(32137);
      default: mag = tbl_t'(32767);
    endcase
    return idx[IDX_W-1] ? -mag : mag;
  endfunction
endpackage

// File: rtl/dtmf_tone_gen.sv
module dtmf_tone_gen #(
  parameter int DIV_W = 8,
  parameter int IDX_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic [IDX_W-1:0] idx_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic             wrap;

  // >= so a shorter divisor selected mid-count wraps at once
  assign wrap = (cnt_q >= (div_i - DIV_W'(1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      idx_q <= '0;
    end else if (!en_i) begin
      cnt_q <= '0;
      idx_q <= '0;
    end else if (wrap) begin
      cnt_q <= '0;
      idx_q <= idx_q + IDX_W'(1);
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end

  assign idx_o = idx_q;
endmodule

// File: rtl/dtmf_sine_lut.sv
module dtmf_sine_lut
  import dtmf_pkg::*;
(
  input  idx_t idx_i,
  output tbl_t val_o
);
  assign val_o = sine_at(idx_i);
endmodule

// File: rtl/dtmf_mixer.sv
module dtmf_mixer #(
  parameter int TBL_W     = 17,
  parameter int OUT_W     = 16,
  parameter int AMP_SHIFT = 2,
  parameter int SUM_W     = TBL_W + 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    row_act_i,
  input  logic                    col_act_i,
  input  logic signed [TBL_W-1:0] row_lut_i,
  input  logic signed [TBL_W-1:0] col_lut_i,
  output logic signed [SUM_W-1:0] sum_o,
  output logic signed [OUT_W-1:0] sample_o,
  output logic                    valid_o
);
  localparam logic signed [SUM_W-1:0] HI = SUM_W'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
  localparam logic signed [SUM_W-1:0] LO = ~HI;

  logic signed [SUM_W-1:0] row_x, col_x, row_s, col_b, col_s;
  logic signed [SUM_W-1:0] row_v, col_v, sum;
  logic signed [OUT_W-1:0] clip;

  assign row_x = {{(SUM_W-TBL_W){row_lut_i[TBL_W-1]}}, row_lut_i};
  assign col_x = {{(SUM_W-TBL_W){col_lut_i[TBL_W-1]}}, col_lut_i};
  assign row_s = row_x >>> AMP_SHIFT;
  assign col_b = col_x >>> AMP_SHIFT;
  // 1.25x pre-emphasis on the high group
  assign col_s = col_b + (col_b >>> 2);

  assign row_v = row_act_i ? row_s : '0;
  assign col_v = col_act_i ? col_s : '0;
  assign sum   = row_v + col_v;
  assign sum_o = sum;

  always_comb begin
    if (sum > HI)      clip = HI[OUT_W-1:0];
    else if (sum < LO) clip = LO[OUT_W-1:0];
    else               clip = sum[OUT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sample_o <= '0;
      valid_o  <= 1'b0;
    end else begin
      sample_o <= clip;
      valid_o  <= row_act_i | col_act_i;
    end
  end
endmodule

// File: rtl/dtmf_synth.sv
module dtmf_synth
  import dtmf_pkg::*;
#(
  parameter int OUT_W     = 16,
  parameter int AMP_SHIFT = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [1:0]              row_sel_i,
  input  logic [1:0]              col_sel_i,
  input  logic                    row_en_i,
  input  logic                    col_en_i,
  input  logic                    off_i,
  output logic signed [OUT_W-1:0] sample_o,
  output logic                    valid_o
);
  localparam int SUM_W = TBL_W + 2;

  logic [NGRP-1:0]         grp_act;
  div_t                    grp_div [NGRP];
  idx_t                    grp_idx [NGRP];
  tbl_t                    grp_lut [NGRP];
  logic signed [SUM_W-1:0] sum_full;

  assign grp_act[0] = row_en_i & ~off_i;
  assign grp_act[1] = col_en_i & ~off_i;
  assign grp_div[0] = row_div(row_sel_i);
  assign grp_div[1] = col_div(col_sel_i);

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    dtmf_tone_gen #(
      .DIV_W(DIV_W),
      .IDX_W(IDX_W)
    ) u_gen (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (grp_act[g]),
      .div_i (grp_div[g]),
      .idx_o (grp_idx[g])
    );
    dtmf_sine_lut u_lut (
      .idx_i(grp_idx[g]),
      .val_o(grp_lut[g])
    );
  end

  dtmf_mixer #(
    .TBL_W    (TBL_W),
    .OUT_W    (OUT_W),
    .AMP_SHIFT(AMP_SHIFT),
    .SUM_W    (SUM_W)
  ) u_mix (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .row_act_i(grp_act[0]),
    .col_act_i(grp_act[1]),
    .row_lut_i(grp_lut[0]),
    .col_lut_i(grp_lut[1]),
    .sum_o    (sum_full),
    .sample_o (sample_o),
    .valid_o  (valid_o)
  );
endmodule

// File: rtl/dtmf_synth_chk.sv
module dtmf_synth_chk #(
  parameter int OUT_W = 16,
  parameter int SUM_W = 19
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    row_en_i,
  input logic                    col_en_i,
  input logic                    off_i,
  input logic [4:0]              row_idx_i,
  input logic [4:0]              col_idx_i,
  input logic signed [SUM_W-1:0] sum_i,
  input logic signed [OUT_W-1:0] sample_i,
  input logic                    valid_i
);
  localparam logic signed [SUM_W-1:0] HI = SUM_W'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
  localparam logic signed [SUM_W-1:0] LO = ~HI;

  // R8
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((!row_en_i || off_i) && (!col_en_i || off_i)) |=> (sample_i == '0 && !valid_i));

  // R9
  off_mute_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_i |=> (sample_i == '0 && !valid_i));

  // R6
  valid_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((row_en_i || col_en_i) && !off_i) |=> valid_i);

  // R10
  row_idx_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!row_en_i || off_i) |=> (row_idx_i == 5'd0));

  // R10
  col_idx_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!col_en_i || off_i) |=> (col_idx_i == 5'd0));

  // R4
  row_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_en_i && !off_i) |=>
      (row_idx_i == $past(row_idx_i) || row_idx_i == $past(row_idx_i) + 5'd1 || row_idx_i == 5'd0));

  // R4
  col_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_en_i && !off_i) |=>
      (col_idx_i == $past(col_idx_i) || col_idx_i == $past(col_idx_i) + 5'd1 || col_idx_i == 5'd0));

  // R7
  clip_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sum_i > HI) |=> (sample_i == {1'b0, {(OUT_W-1){1'b1}}}));

  // R7
  clip_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sum_i < LO) |=> (sample_i == {1'b1, {(OUT_W-1){1'b0}}}));
endmodule

bind dtmf_synth dtmf_synth_chk #(
  .OUT_W(OUT_W),
  .SUM_W(SUM_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .row_en_i (row_en_i),
  .col_en_i (col_en_i),
  .off_i    (off_i),
  .row_idx_i(grp_idx[0]),
  .col_idx_i(grp_idx[1]),
  .sum_i    (sum_full),
  .sample_i (sample_o),
  .valid_i  (valid_o)
);

// File: tb/dtmf_synth_tb.sv
`timescale 1ns/1ps
module dtmf_synth_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] row_sel = '0, col_sel = '0;
  logic row_en = 1'b0, col_en = 1'b0, off = 1'b0;
  logic signed [15:0] samp_a, samp_b;
  logic valid_a, valid_b;

  int n_run = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dtmf_synth u_dut (
    .clk_i(clk), .rst_ni(rst_n), .row_sel_i(row_sel), .col_sel_i(col_sel),
    .row_en_i(row_en), .col_en_i(col_en), .off_i(off),
    .sample_o(samp_a), .valid_o(valid_a));

  dtmf_synth #(.OUT_W(16), .AMP_SHIFT(0)) u_dut_sat (
    .clk_i(clk), .rst_ni(rst_n), .row_sel_i(row_sel), .col_sel_i(col_sel),
    .row_en_i(row_en), .col_en_i(col_en), .off_i(off),
    .sample_o(samp_b), .valid_o(valid_b));

  int row_n [4] = '{160, 146, 132, 118};
  int col_n [4] = '{92, 84, 76, 68};
  int row_nom [4] = '{697, 770, 852, 941};
  int col_nom [4] = '{1209, 1336, 1477, 1633};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sine_ref(int k);
    real v;
    v = 32767.0 * $sin(2.0 * 3.14159265358979 * k / 32.0);
    return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
  endfunction

  function automatic int clip16(int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  // reference model: [0] shift 2, [1] shift 0
  int m_ri [2], m_rc [2], m_ci [2], m_cc [2], m_s [2];
  bit m_v [2];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < 2; s++) begin
        m_ri[s] = 0; m_rc[s] = 0; m_ci[s] = 0; m_cc[s] = 0; m_s[s] = 0; m_v[s] = 0;
      end
    end else begin
      for (int s = 0; s < 2; s++) begin
        int sh, r, c, rv, cv;
        bit ra, ca;
        sh = (s == 0) ? 2 : 0;
        ra = row_en && !off;
        ca = col_en && !off;
        r = sine_ref(m_ri[s]) >>> sh;
        c = sine_ref(m_ci[s]) >>> sh;
        rv = ra ? r : 0;
        cv = ca ? (c + (c >>> 2)) : 0;
        m_s[s] = clip16(rv + cv);
        m_v[s] = ra || ca;
        if (!ra) begin m_rc[s] = 0; m_ri[s] = 0; end
        else if (m_rc[s] >= row_n[row_sel] - 1) begin m_rc[s] = 0; m_ri[s] = (m_ri[s] + 1) % 32; end
        else m_rc[s]++;
        if (!ca) begin m_cc[s] = 0; m_ci[s] = 0; end
        else if (m_cc[s] >= col_n[col_sel] - 1) begin m_cc[s] = 0; m_ci[s] = (m_ci[s] + 1) % 32; end
        else m_cc[s]++;
      end
    end
  end

  // per-clock comparison away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done) begin
      check(int'(samp_a) == m_s[0], "R6 sample (shift 2)", int'(samp_a), m_s[0]);
      check(valid_a == m_v[0], "R6 valid", int'(valid_a), int'(m_v[0]));
      check(int'(samp_b) == m_s[1], "R7 sample (shift 0)", int'(samp_b), m_s[1]);
      check(valid_b == m_v[1], "R6 valid (shift 0)", int'(valid_b), int'(m_v[1]));
    end
    if (cyc > 200000 && !done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic quiet(input int n);
    row_en = 1'b0; col_en = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // period between two rising zero crossings of samp_a, plus extremes
  task automatic meas(output int per, output int pk, output int mn);
    int t, first, prev, cur;
    t = 0; first = -1; per = -1; prev = 0; pk = -100000; mn = 100000;
    while (per < 0 && t < 20000) begin
      @(negedge clk);
      cur = int'(samp_a);
      if (first >= 0) begin
        if (cur > pk) pk = cur;
        if (cur < mn) mn = cur;
      end
      if (prev <= 0 && cur > 0) begin
        if (first < 0) first = t; else per = t - first;
      end
      prev = cur;
      t++;
    end
  endtask

  task automatic freq_chk(input int per, input int n, input int nom, input string req);
    real f, err;
    check(per == 32 * n, req, per, 32 * n);
    f = 3579545.0 / real'(per);
    err = (f - real'(nom)) / real'(nom);
    check(err <= 0.0075 && err >= -0.0075, {req, " tolerance (Hz)"}, $rtoi(f), nom);
  endtask

  initial begin
    int per, pk, mn, k, hi, lo;
    repeat (3) @(negedge clk);
    // R1
    check(samp_a == 0 && samp_b == 0, "R1 sample in reset", int'(samp_a), 0);
    check(!valid_a && !valid_b, "R1 valid in reset", int'(valid_a), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R8
    check(samp_a == 0 && !valid_a, "R8 idle output", int'(samp_a), 0);

    // R2: row-only frequencies
    for (int i = 0; i < 4; i++) begin
      quiet(2);
      row_sel = 2'(i); row_en = 1'b1;
      meas(per, pk, mn);
      freq_chk(per, row_n[i], row_nom[i], "R2 row period");
      if (i == 0) begin
        check(pk == 8191, "R5 row peak", pk, 8191);
        check(mn == -8192, "R5 row trough", mn, -8192);
      end
    end

    // R3: column-only frequencies
    for (int i = 0; i < 4; i++) begin
      quiet(2);
      col_sel = 2'(i); col_en = 1'b1;
      meas(per, pk, mn);
      freq_chk(per, col_n[i], col_nom[i], "R3 col period");
      if (i == 0) begin
        check(pk == 10238, "R5 col peak", pk, 10238);
        check(mn == -10240, "R5 col trough", mn, -10240);
      end
    end

    // R4: dual tone with a live column select change
    quiet(2);
    row_sel = 2'd1; col_sel = 2'd2; row_en = 1'b1; col_en = 1'b1;
    repeat (1500) @(negedge clk);
    col_sel = 2'd3;
    repeat (1500) @(negedge clk);
    check(valid_a, "R4 dual tone running", int'(valid_a), 1);

    // R9: off overrides enables
    off = 1'b1;
    @(negedge clk);
    check(samp_a == 0 && !valid_a, "R9 off mutes sample", int'(samp_a), 0);
    repeat (5) @(negedge clk);
    check(samp_b == 0 && !valid_b, "R9 off holds (shift 0)", int'(samp_b), 0);

    // R10: restart timing from index 0
    col_en = 1'b0; row_sel = 2'd0;
    @(negedge clk);
    off = 1'b0;
    k = 0;
    @(negedge clk); k++;
    check(valid_a, "R6 valid one cycle after enable", int'(valid_a), 1);
    while (samp_a <= 0 && k < 1000) begin @(negedge clk); k++; end
    check(k == 161, "R10 first positive sample after re-enable", k, 161);

    // R7: clipping on the zero-shift instance
    quiet(2);
    row_sel = 2'd0; col_sel = 2'd0; row_en = 1'b1; col_en = 1'b1;
    hi = -100000; lo = 100000;
    repeat (6000) begin
      @(negedge clk);
      if (int'(samp_b) > hi) hi = int'(samp_b);
      if (int'(samp_b) < lo) lo = int'(samp_b);
    end
    check(hi == 32767, "R7 positive rail", hi, 32767);
    check(lo == -32768, "R7 negative rail", lo, -32768);

    quiet(3);
    // R8
    check(samp_a == 0 && !valid_a && samp_b == 0, "R8 both disabled", int'(samp_a), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule